// File: doc/BRIEF.md
# Per-Channel Piecewise-Linear Gamma Corrector

This block sits in a 24-bit RGB pixel stream and gives each colour component its own transfer curve. A curve is held as 16 programmable set points, one at the start of each 16-code segment of the 8-bit input range. An input value picks a segment with its upper nibble. The output is then found on the straight line from that segment's set point to the next one, weighted by the lower nibble. The line is closed at the top by a fixed end value of 255.

The horizontal sync, vertical sync and data-enable qualifiers travel beside the data through a delay line of the same depth, so the timing of a frame is kept. Set points are written through a small write port into a shadow bank. The shadow bank is copied to the working bank only when a new frame starts, so a curve never changes part-way down a picture. A mute input is sampled at that same frame start. While mute is held, all colour outputs are zero for the whole following frame.

Top module: `pwl_gamma`

## Requirements
- R1: After reset every curve is the identity ramp: set point k holds 16*k, so an input x below 240 comes out as x unchanged.
- R2: The three components are mapped independently. pix_in[23:16] (red) uses curve 0, pix_in[15:8] (green) uses curve 1 and pix_in[7:0] (blue) uses curve 2, and each result lands at the same bit position in pix_out.
- R3: For an input with segment s = x[7:4] and weight f = x[3:0], the output is lo + floor(((hi - lo) * f + 8) / 16), clamped to 0..255. Here lo is set point s and hi is set point s+1.
- R4: In segment 15, hi is the fixed value 255 rather than a set point.
- R5: An input whose low nibble is zero returns its set point exactly.
- R6: pix_out, hsync_out, vsync_out and de_out show the values applied to the inputs exactly two clock cycles earlier. Mute never blanks the sync or enable outputs.
- R7: A frame start is a cycle in which vsync_in is high after being low in the previous cycle. mute_in is sampled only in that cycle. From the next input cycle until the next frame start, a sampled high forces all 24 output data bits to zero.
- R8: A write (cfg_we high, channel cfg_chan, set point cfg_idx, value cfg_val) goes to a shadow bank. The working curves take the shadow contents at the next frame start, and the pixel in that frame-start cycle still uses the old curves.
- R9: A write with cfg_chan = 3 changes no curve.
- R10: While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | 24 | Input pixel, red in the top byte |
| hsync_in | input | 1 | Horizontal sync in |
| vsync_in | input | 1 | Vertical sync in, active high |
| de_in | input | 1 | Data enable in |
| mute_in | input | 1 | Mute request, sampled at frame start |
| cfg_we | input | 1 | Set-point write strobe |
| cfg_chan | input | 2 | Curve select: 0 red, 1 green, 2 blue, 3 none |
| cfg_idx | input | 4 | Set-point number within the curve |
| cfg_val | input | 8 | Set-point value |
| pix_out | output | 24 | Corrected pixel |
| hsync_out | output | 1 | Delayed horizontal sync |
| vsync_out | output | 1 | Delayed vertical sync |
| de_out | output | 1 | Delayed data enable |

## Verification
A full 0..255 ramp on all three components after reset confirms the identity curves and the alignment of the two-stage path. Three differently shaped curves are then loaded: a falling line, a square law and a flat-then-steep curve. Ramps and breakpoint-only values driven through them separate per-channel independence, the rounding term, the fixed top end and exact set-point hits. Pixels sent between a write and the next vertical sync show that nothing takes effect early, and a write to channel 3 shows that it is dropped. Raising mute mid-frame, then crossing a vertical sync edge, shows that blanking begins only at the boundary while the sync outputs keep running.

// File: rtl/pwl_gamma_pkg.sv
package pwl_gamma_pkg;

    // Curve selector codes on the write port
    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2,
        CH_NONE  = 2'd3
    } chan_sel_e;

    // Default set point k of an identity curve
    function automatic int unsigned ident_point(input int unsigned k, input int unsigned frac_bits);
        return k << frac_bits;
    endfunction

endpackage

// File: rtl/pwl_gamma_bank.sv
module pwl_gamma_bank #(
    parameter int DW       = 8,
    parameter int SEG_BITS = 4,
    parameter int NCH      = 3,
    parameter int CH_BITS  = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    apply_i,
    input  logic                                    we_i,
    input  logic [CH_BITS-1:0]                      ch_i,
    input  logic [SEG_BITS-1:0]                     idx_i,
    input  logic [DW-1:0]                           val_i,
    output logic [NCH-1:0][(1<<SEG_BITS)-1:0][DW-1:0] pts_o
);
    import pwl_gamma_pkg::*;

    localparam int NPTS      = 1 << SEG_BITS;
    localparam int FRAC_BITS = DW - SEG_BITS;

    typedef struct packed {
        logic [NCH-1:0][NPTS-1:0][DW-1:0] shadow;
        logic [NCH-1:0][NPTS-1:0][DW-1:0] active;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCH; c++) begin
            if (we_i && (int'(ch_i) == c)) begin
                st_d.shadow[c][idx_i] = val_i;
            end
        end
        if (apply_i) begin
            st_d.active = st_q.shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                for (int k = 0; k < NPTS; k++) begin
                    st_q.shadow[c][k] <= DW'(ident_point(k, FRAC_BITS));
                    st_q.active[c][k] <= DW'(ident_point(k, FRAC_BITS));
                end
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign pts_o = st_q.active;

    // R8: working curves move only on a frame start
    a_r8_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_i |=> $stable(st_q.active));

    // R9: a write to an absent channel leaves the shadow bank alone
    a_r9_bad_chan_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (int'(ch_i) >= NCH)) |=> $stable(st_q.shadow));

endmodule

// File: rtl/pwl_gamma_interp.sv
module pwl_gamma_interp #(
    parameter int DW       = 8,
    parameter int SEG_BITS = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [(1<<SEG_BITS)-1:0][DW-1:0]    pts_i,
    input  logic [DW-1:0]                       pix_i,
    input  logic                                mute_i,
    output logic [DW-1:0]                       pix_o
);
    localparam int NPTS      = 1 << SEG_BITS;
    localparam int FRAC_BITS = DW - SEG_BITS;
    localparam int PW        = DW + FRAC_BITS + 3;
    localparam logic [DW-1:0] END_VAL = '1;
    localparam logic signed [PW-1:0] ROUND = PW'(1) <<< (FRAC_BITS - 1);
    localparam logic signed [PW-1:0] MAXV  = PW'((1 << DW) - 1);

    typedef struct packed {
        logic [DW-1:0]        lo;
        logic [DW-1:0]        hi;
        logic [FRAC_BITS-1:0] frac;
        logic                 mute;
    } stage_a_t;

    stage_a_t a_d, a_q;
    logic [DW-1:0] out_d, out_q;

    logic [SEG_BITS-1:0]     seg;
    logic signed [PW-1:0]    diff, prod, step, sum;

    // Stage A: segment lookup
    always_comb begin
        seg      = pix_i[DW-1 -: SEG_BITS];
        a_d.lo   = pts_i[seg];
        a_d.hi   = (seg == SEG_BITS'(NPTS - 1)) ? END_VAL : pts_i[SEG_BITS'(seg + 1'b1)];
        a_d.frac = pix_i[FRAC_BITS-1:0];
        a_d.mute = mute_i;
    end

    // Stage B: weighted step, rounding, clamp, mute
    always_comb begin
        diff = $signed(PW'(a_q.hi)) - $signed(PW'(a_q.lo));
        prod = diff * $signed(PW'(a_q.frac)) + ROUND;
        step = prod >>> FRAC_BITS;
        sum  = $signed(PW'(a_q.lo)) + step;
        if (sum < 0) begin
            out_d = '0;
        end else if (sum > MAXV) begin
            out_d = END_VAL;
        end else begin
            out_d = DW'(sum);
        end
        if (a_q.mute) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            out_q <= '0;
        end else begin
            a_q   <= a_d;
            out_q <= out_d;
        end
    end

    assign pix_o = out_q;

    // R3: the interpolated value never leaves the span of its two end points
    a_r3_within_span: assert property (@(posedge clk) disable iff (!rst_n)
        !a_q.mute |=> ((pix_o >= $past(a_q.lo) || pix_o >= $past(a_q.hi)) &&
                       (pix_o <= $past(a_q.lo) || pix_o <= $past(a_q.hi))));

    // R7: a muted pixel leaves the stage as zero
    a_r7_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        a_q.mute |=> (pix_o == '0));

endmodule

// File: rtl/pwl_gamma.sv
module pwl_gamma #(
    parameter int DW       = 8,
    parameter int SEG_BITS = 4,
    parameter int NCH      = 3,
    parameter int CH_BITS  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH*DW-1:0]     pix_in,
    input  logic                  hsync_in,
    input  logic                  vsync_in,
    input  logic                  de_in,
    input  logic                  mute_in,
    input  logic                  cfg_we,
    input  logic [CH_BITS-1:0]    cfg_chan,
    input  logic [SEG_BITS-1:0]   cfg_idx,
    input  logic [DW-1:0]         cfg_val,
    output logic [NCH*DW-1:0]     pix_out,
    output logic                  hsync_out,
    output logic                  vsync_out,
    output logic                  de_out
);
    localparam int NPTS = 1 << SEG_BITS;
    localparam int LAT  = 2;   // depth of the interpolation pipe

    typedef struct packed {
        logic                  vs_prev;
        logic                  mute;
        logic [LAT-1:0][2:0]   sync;   // {hsync, vsync, de} per stage
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic frame_start;
    logic [NCH-1:0][NPTS-1:0][DW-1:0] pts;

    always_comb begin
        ctl_d         = ctl_q;
        frame_start   = vsync_in && !ctl_q.vs_prev;
        ctl_d.vs_prev = vsync_in;
        if (frame_start) begin
            ctl_d.mute = mute_in;
        end
        ctl_d.sync[0] = {hsync_in, vsync_in, de_in};
        for (int s = 1; s < LAT; s++) begin
            ctl_d.sync[s] = ctl_q.sync[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign {hsync_out, vsync_out, de_out} = ctl_q.sync[LAT-1];

    pwl_gamma_bank #(
        .DW(DW), .SEG_BITS(SEG_BITS), .NCH(NCH), .CH_BITS(CH_BITS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .apply_i (frame_start),
        .we_i    (cfg_we),
        .ch_i    (cfg_chan),
        .idx_i   (cfg_idx),
        .val_i   (cfg_val),
        .pts_o   (pts)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwl_gamma_interp #(
            .DW(DW), .SEG_BITS(SEG_BITS)
        ) u_interp (
            .clk    (clk),
            .rst_n  (rst_n),
            .pts_i  (pts[c]),
            .pix_i  (pix_in[(NCH-1-c)*DW +: DW]),
            .mute_i (ctl_q.mute),
            .pix_o  (pix_out[(NCH-1-c)*DW +: DW])
        );
    end

    // Cycles since reset, for checks that look back over the pipe
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R6: qualifiers come out exactly LAT cycles later
    a_r6_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (de_out == $past(de_in, 2) &&
                              hsync_out == $past(hsync_in, 2) &&
                              vsync_out == $past(vsync_in, 2)));

    // R7: the mute state changes only on a frame start
    a_r7_mute_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(ctl_q.mute));

    // R10: outputs are zero while reset is held
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> (pix_out == '0 && !de_out && !hsync_out && !vsync_out)));

endmodule

// File: tb/pwl_gamma_bench.sv
`timescale 1ns/1ps
module pwl_gamma_bench;

    typedef struct {
        logic [23:0] pix;
        logic        hs;
        logic        vs;
        logic        de;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pix_in = '0;
    logic        hsync_in = 1'b0, vsync_in = 1'b0, de_in = 1'b0, mute_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_chan = '0;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_val = '0;
    logic [23:0] pix_out;
    logic        hsync_out, vsync_out, de_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    exp_t q[$];

    int  sh[3][16];
    int  ac[3][16];
    bit  m_mute = 1'b0;
    bit  m_vs_prev = 1'b0;

    always #2.5 clk = ~clk;

    pwl_gamma u_pwl_gamma (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .de_in(de_in), .mute_in(mute_in),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_idx(cfg_idx), .cfg_val(cfg_val),
        .pix_out(pix_out), .hsync_out(hsync_out), .vsync_out(vsync_out), .de_out(de_out)
    );

    function automatic int model(input int c, input int x);
        int lo, hi, f, t, st, r;
        lo = ac[c][x / 16];
        hi = (x / 16 == 15) ? 255 : ac[c][x / 16 + 1];
        f  = x % 16;
        t  = (hi - lo) * f + 8;
        st = (t >= 0) ? t / 16 : -((-t + 15) / 16);
        r  = lo + st;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Driver: one input cycle, expected item pushed to the scoreboard
    task automatic step(input logic [23:0] p, input logic h, input logic v, input logic d, input string tag);
        exp_t e;
        bit fs;
        @(negedge clk);
        pix_in = p; hsync_in = h; vsync_in = v; de_in = d;
        e.hs = h; e.vs = v; e.de = d; e.tag = tag;
        if (m_mute) e.pix = '0;
        else e.pix = {8'(model(0, p[23:16])), 8'(model(1, p[15:8])), 8'(model(2, p[7:0]))};
        q.push_back(e);
        fs = v && !m_vs_prev;
        if (fs) begin
            ac = sh;
            m_mute = mute_in;
        end
        m_vs_prev = v;
    endtask

    task automatic wr(input int ch, input int idx, input int val);
        cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_idx = 4'(idx); cfg_val = 8'(val);
        step(24'h0, 1'b0, 1'b0, 1'b0, "R8");
        cfg_we = 1'b0;
        if (ch < 3) sh[ch][idx] = val;
    endtask

    task automatic frame_edge(input string tag);
        step(24'h0, 1'b0, 1'b1, 1'b0, tag);
        step(24'h0, 1'b0, 1'b1, 1'b0, tag);
        step(24'h0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // Monitor: pops once two items are in flight
    always @(posedge clk) begin
        #1;
        if (rst_n && q.size() >= 2) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (pix_out !== e.pix || hsync_out !== e.hs || vsync_out !== e.vs || de_out !== e.de) begin
                errors++;
                $display("FAIL %s: pix=%h h=%b v=%b de=%b expected pix=%h h=%b v=%b de=%b",
                         e.tag, pix_out, hsync_out, vsync_out, de_out, e.pix, e.hs, e.vs, e.de);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 3; c++)
            for (int k = 0; k < 16; k++) begin
                sh[c][k] = 16 * k;
                ac[c][k] = 16 * k;
            end
        pix_in = 24'hA5C3F0; de_in = 1'b1; hsync_in = 1'b1; vsync_in = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        checks++;
        if (pix_out !== '0 || de_out !== 1'b0 || hsync_out !== 1'b0 || vsync_out !== 1'b0) begin
            errors++;
            $display("FAIL R10: pix=%h de=%b h=%b v=%b expected all zero", pix_out, de_out, hsync_out, vsync_out);
        end
        @(negedge clk);
        pix_in = '0; de_in = 1'b0; hsync_in = 1'b0; vsync_in = 1'b0;
        rst_n = 1'b1;

        // R1 / R6: identity ramp with toggling sync
        for (int x = 0; x < 256; x++)
            step({8'(x), 8'(255 - x), 8'(x ^ 8'h5A)}, 1'(x % 7 == 0), 1'b0, 1'(x % 5 != 0), "R1");

        // Load three different curves into the shadow bank
        for (int k = 0; k < 16; k++) begin
            wr(0, k, 255 - 16 * k);
            wr(1, k, (k * k > 255) ? 255 : k * k);
            wr(2, k, (k < 8) ? 10 : 10 + (k - 7) * 30);
        end
        // R8: nothing changes before the frame boundary
        for (int x = 0; x < 256; x += 17)
            step({8'(x), 8'(x), 8'(x)}, 1'b0, 1'b0, 1'b1, "R8");
        frame_edge("R8");

        // R2 / R3: ramps through the new curves, channels out of step
        for (int x = 0; x < 256; x++)
            step({8'(x), 8'((x * 3) % 256), 8'(255 - x)}, 1'b0, 1'b0, 1'b1, "R3");
        // R5: breakpoints
        for (int k = 0; k < 16; k++)
            step({8'(k * 16), 8'(k * 16), 8'(k * 16)}, 1'b1, 1'b0, 1'b1, "R5");
        // R4: top segment
        for (int x = 240; x < 256; x++)
            step({8'(x), 8'(x), 8'(x)}, 1'b0, 1'b0, 1'b1, "R4");
        // R2: one channel moving, others fixed
        for (int x = 0; x < 256; x += 5)
            step({8'd100, 8'(x), 8'd200}, 1'b0, 1'b0, 1'b1, "R2");

        // R9: channel 3 writes are dropped
        for (int k = 0; k < 16; k++) wr(3, k, 8'h77);
        frame_edge("R9");
        for (int x = 0; x < 256; x += 3)
            step({8'(x), 8'(x), 8'(x)}, 1'b0, 1'b0, 1'b1, "R9");

        // R7: mute raised mid-frame has no effect until the boundary
        mute_in = 1'b1;
        for (int x = 0; x < 40; x++)
            step({8'(x * 6), 8'(x), 8'(x * 3)}, 1'b0, 1'b0, 1'b1, "R7");
        frame_edge("R7");
        for (int x = 0; x < 40; x++)
            step({8'(x * 6), 8'(x), 8'(x * 3)}, 1'(x % 4 == 0), 1'b0, 1'b1, "R7");
        mute_in = 1'b0;
        for (int x = 0; x < 10; x++)
            step({8'(x * 20), 8'(x), 8'(x)}, 1'b0, 1'b0, 1'b1, "R7");
        frame_edge("R7");
        for (int x = 0; x < 40; x++)
            step({8'(x * 6), 8'(x), 8'(x * 3)}, 1'b0, 1'b0, 1'b1, "R7");

        for (int i = 0; i < 3; i++) step(24'h0, 1'b0, 1'b0, 1'b0, "R6");
        done = 1'b1;
        report();
        $finish;
    end

endmodule